// File: doc/BRIEF.md
# Four-Thread Barrel Pipeline Controller

This block sequences four hardware threads through a five-stage pipeline (fetch, decode, execute, memory, writeback) that has no bypass paths and no interlocks. Every cycle it issues an instruction-memory request on behalf of a different thread, in a fixed rotation. Each thread therefore advances at one quarter of the pipeline clock. Because the rotation is fixed, an instruction has finished writeback before the next instruction of the same thread reads its operands. Dependency checking and forwarding are not needed.

The controller keeps one program counter per thread. A thread's counter moves forward by one instruction each time that thread fetches. A branch resolved in the execute stage can load a new target into the counter of its own thread. The redirect always lands before that thread's next fetch slot, so no wrong-path instruction is ever fetched and nothing has to be squashed. A thread tag travels with every instruction. The controller exposes the tag held in each stage, the register-bank select for operand reads in decode, and per-bank write enables at writeback. The surrounding datapath uses these to reach the correct thread's register set.

Top module: `barrel_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `imem_req_valid` is low, every bit of `stage_vld` is low and `rf_bank_we` is zero. The first fetch of thread t uses address `RESET_PC + t*THREAD_PC_STRIDE`, which with the defaults is t*0x1000.
- R2: Starting in the second cycle after reset release, `imem_req_valid` is high in every cycle. `imem_req_tid` follows 0,1,2,3,0,… and starts at 0.
- R3: `imem_req_addr` is the current program counter of thread `imem_req_tid`. After a fetch with no redirect for that thread, the thread's counter has grown by `INSN_BYTES` (4).
- R4: When `redir_valid[t]` is high in a cycle where thread t does not fetch, the next fetch of thread t uses `redir_target[t*32 +: 32]`.
- R5: When `redir_valid[t]` is high in the same cycle that thread t fetches, that fetch still uses the old counter value. The next fetch of t then uses the redirect target, not the incremented value.
- R6: Redirects to several threads in the same cycle each take effect for their own thread. Threads without a redirect are unaffected.
- R7: Stage k (0 = fetch, 1 = decode, 2 = execute, 3 = memory, 4 = writeback) reports its valid bit in `stage_vld[k]` and its thread tag in `stage_tid[2k+1:2k]`. These equal the request valid and thread tag issued k cycles earlier, and a stage is invalid if that cycle came before the first fetch.
- R8: `rf_rd_bank` equals the decode-stage thread tag whenever the decode stage is valid.
- R9: `rf_wr_bank` equals the writeback-stage tag. `rf_bank_we` has bit w set exactly when `wb_we_req` is high, the writeback stage is valid and its tag is w, and it is zero otherwise.
- R10: Among the decode, execute, memory and writeback stages, any two valid stages hold different thread tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_req_valid | output | 1 | Instruction fetch request valid |
| imem_req_addr | output | ADDR_W | Fetch address (PC of the issuing thread) |
| imem_req_tid | output | TID_W | Thread issuing the fetch |
| stage_vld | output | NSTAGE | Per-stage valid, bit 0 = fetch … bit 4 = writeback |
| stage_tid | output | NSTAGE*TID_W | Per-stage thread tags, field k at bits [k*TID_W +: TID_W] |
| redir_valid | input | NT | Per-thread PC redirect strobe from execute |
| redir_target | input | NT*ADDR_W | Per-thread redirect target, thread t at [t*ADDR_W +: ADDR_W] |
| wb_we_req | input | 1 | Writeback instruction wants to write the register file |
| rf_rd_bank | output | TID_W | Register bank for operand reads (decode tag) |
| rf_wr_bank | output | TID_W | Register bank for writeback (writeback tag) |
| rf_bank_we | output | NT | One-hot register bank write enable |

## Verification
The interesting overlap is a redirect arriving for a thread in the very cycle that thread holds the fetch slot. In that cycle the counter has to choose between the increment and the jump while still serving the old address. The stimulus forces this case alone, in two consecutive redirects to one thread where the second collides with its fetch, and together with simultaneous redirects to three and to four threads. A scoreboard built from the rotation and the redirect rules predicts every fetch address. A collision is judged correct only if the colliding fetch shows the old counter and the following fetch of that thread shows the new target.

// File: rtl/barrel_pkg.sv
package barrel_pkg;

    // Sequencer phase: idle right after reset, then issuing every cycle
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Next-value source for one thread's program counter
    typedef enum logic [1:0] {
        PC_HOLD = 2'd0,
        PC_STEP = 2'd1,
        PC_JUMP = 2'd2
    } pc_sel_e;

endpackage

// File: rtl/barrel_slot_sel.sv
module barrel_slot_sel
    import barrel_pkg::*;
#(
    parameter int NT = 4,
    parameter int TID_W = $clog2(NT)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             fetch_valid,
    output logic [TID_W-1:0] fetch_tid
);

    localparam logic [TID_W-1:0] LAST_SLOT = TID_W'(NT - 1);

    seq_state_e       state_q, state_d;
    logic [TID_W-1:0] slot_q, slot_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
        end
    end

    // Transitions: IDLE -> RUN once, RUN rotates the slot each cycle
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        unique case (state_q)
            SEQ_IDLE: state_d = SEQ_RUN;
            SEQ_RUN:  slot_d  = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        fetch_valid = (state_q == SEQ_RUN);
        fetch_tid   = slot_q;
    end

endmodule

// File: rtl/barrel_pc_bank.sv
module barrel_pc_bank
    import barrel_pkg::*;
#(
    parameter int NT = 4,
    parameter int ADDR_W = 32,
    parameter int TID_W = $clog2(NT),
    parameter logic [ADDR_W-1:0] RESET_PC = '0,
    parameter logic [ADDR_W-1:0] THREAD_PC_STRIDE = 'h1000,
    parameter int INSN_BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fetch_valid,
    input  logic [TID_W-1:0]     fetch_tid,
    input  logic [NT-1:0]        redir_valid,
    input  logic [NT*ADDR_W-1:0] redir_target,
    output logic [ADDR_W-1:0]    fetch_addr
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    logic [ADDR_W-1:0] pc_q [NT];
    logic [ADDR_W-1:0] pc_plus;

    // Only one thread fetches per cycle, so a single incrementer serves all
    assign fetch_addr = pc_q[fetch_tid];
    assign pc_plus    = fetch_addr + STEP;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        pc_sel_e           sel;
        logic [ADDR_W-1:0] nxt;
        logic              owns_slot;

        assign owns_slot = fetch_valid && (fetch_tid == TID_W'(t));

        always_comb begin
            if (redir_valid[t]) begin
                sel = PC_JUMP;
            end else if (owns_slot) begin
                sel = PC_STEP;
            end else begin
                sel = PC_HOLD;
            end
            unique case (sel)
                PC_JUMP: nxt = redir_target[t*ADDR_W +: ADDR_W];
                PC_STEP: nxt = pc_plus;
                default: nxt = pc_q[t];
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pc_q[t] <= RESET_PC + ADDR_W'(t) * THREAD_PC_STRIDE;
            end else begin
                pc_q[t] <= nxt;
            end
        end
    end

endmodule

// File: rtl/barrel_tag_pipe.sv
module barrel_tag_pipe #(
    parameter int NSTAGE = 5,
    parameter int TID_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    head_vld,
    input  logic [TID_W-1:0]        head_tid,
    output logic [NSTAGE-1:0]       out_vld,
    output logic [NSTAGE*TID_W-1:0] out_tid
);

    // Registers for stages 1 .. NSTAGE-1; stage 0 is the live fetch slot
    logic [NSTAGE-1:1]             vld_q;
    logic [NSTAGE-1:1][TID_W-1:0]  tid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            tid_q <= '0;
        end else begin
            vld_q[1] <= head_vld;
            tid_q[1] <= head_tid;
            for (int k = 2; k < NSTAGE; k++) begin
                vld_q[k] <= vld_q[k-1];
                tid_q[k] <= tid_q[k-1];
            end
        end
    end

    assign out_vld = {vld_q, head_vld};
    assign out_tid = {tid_q, head_tid};

endmodule

// File: rtl/barrel_ctrl.sv
module barrel_ctrl
    import barrel_pkg::*;
#(
    parameter int NT = 4,
    parameter int NSTAGE = 5,
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] RESET_PC = '0,
    parameter logic [ADDR_W-1:0] THREAD_PC_STRIDE = 'h1000,
    parameter int INSN_BYTES = 4,
    localparam int TID_W = $clog2(NT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic                    imem_req_valid,
    output logic [ADDR_W-1:0]       imem_req_addr,
    output logic [TID_W-1:0]        imem_req_tid,
    output logic [NSTAGE-1:0]       stage_vld,
    output logic [NSTAGE*TID_W-1:0] stage_tid,
    input  logic [NT-1:0]           redir_valid,
    input  logic [NT*ADDR_W-1:0]    redir_target,
    input  logic                    wb_we_req,
    output logic [TID_W-1:0]        rf_rd_bank,
    output logic [TID_W-1:0]        rf_wr_bank,
    output logic [NT-1:0]           rf_bank_we
);

    localparam int DEC_STAGE = 1;
    localparam int WB_STAGE  = NSTAGE - 1;

    logic             fetch_valid;
    logic [TID_W-1:0] fetch_tid;
    logic             wb_vld;

    barrel_slot_sel #(
        .NT    (NT),
        .TID_W (TID_W)
    ) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_valid (fetch_valid),
        .fetch_tid   (fetch_tid)
    );

    barrel_pc_bank #(
        .NT               (NT),
        .ADDR_W           (ADDR_W),
        .TID_W            (TID_W),
        .RESET_PC         (RESET_PC),
        .THREAD_PC_STRIDE (THREAD_PC_STRIDE),
        .INSN_BYTES       (INSN_BYTES)
    ) u_pcs (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_valid  (fetch_valid),
        .fetch_tid    (fetch_tid),
        .redir_valid  (redir_valid),
        .redir_target (redir_target),
        .fetch_addr   (imem_req_addr)
    );

    barrel_tag_pipe #(
        .NSTAGE (NSTAGE),
        .TID_W  (TID_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .head_vld (fetch_valid),
        .head_tid (fetch_tid),
        .out_vld  (stage_vld),
        .out_tid  (stage_tid)
    );

    assign imem_req_valid = fetch_valid;
    assign imem_req_tid   = fetch_tid;

    assign rf_rd_bank = stage_tid[DEC_STAGE*TID_W +: TID_W];
    assign rf_wr_bank = stage_tid[WB_STAGE*TID_W +: TID_W];
    assign wb_vld     = stage_vld[WB_STAGE];

    for (genvar b = 0; b < NT; b++) begin : g_bank_we
        assign rf_bank_we[b] = wb_we_req && wb_vld && (rf_wr_bank == TID_W'(b));
    end

endmodule

// File: rtl/barrel_ctrl_chk.sv
module barrel_ctrl_chk #(
    parameter int NT = 4,
    parameter int NSTAGE = 5,
    parameter int ADDR_W = 32,
    parameter int INSN_BYTES = 4,
    localparam int TID_W = $clog2(NT)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    imem_req_valid,
    input logic [ADDR_W-1:0]       imem_req_addr,
    input logic [TID_W-1:0]        imem_req_tid,
    input logic [NSTAGE-1:0]       stage_vld,
    input logic [NSTAGE*TID_W-1:0] stage_tid,
    input logic [NT-1:0]           redir_valid,
    input logic [NT*ADDR_W-1:0]    redir_target,
    input logic                    wb_we_req,
    input logic [TID_W-1:0]        rf_rd_bank,
    input logic [TID_W-1:0]        rf_wr_bank,
    input logic [NT-1:0]           rf_bank_we
);

    logic             prev_vld_q;
    logic [TID_W-1:0] prev_tid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_vld_q <= 1'b0;
            prev_tid_q <= '0;
        end else begin
            prev_vld_q <= imem_req_valid;
            prev_tid_q <= imem_req_tid;
        end
    end

    // R2: once issuing, keep issuing and advance one thread per cycle
    p_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prev_vld_q |-> (imem_req_valid && imem_req_tid == TID_W'(prev_tid_q + 1'b1)));

    // Per-thread address tracking for R3, R4 and R5
    for (genvar t = 0; t < NT; t++) begin : g_trk
        logic              known_q;
        logic              pend_q;
        logic [ADDR_W-1:0] exp_q;
        logic              fetch_t;

        assign fetch_t = imem_req_valid && (imem_req_tid == TID_W'(t));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                known_q <= 1'b0;
                pend_q  <= 1'b0;
                exp_q   <= '0;
            end else if (redir_valid[t]) begin
                known_q <= 1'b1;
                pend_q  <= 1'b1;
                exp_q   <= redir_target[t*ADDR_W +: ADDR_W];
            end else if (fetch_t) begin
                known_q <= 1'b1;
                pend_q  <= 1'b0;
                exp_q   <= imem_req_addr + ADDR_W'(INSN_BYTES);
            end
        end

        p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (fetch_t && known_q && !pend_q) |-> (imem_req_addr == exp_q));

        // Also covers R5: the target pending from a colliding redirect
        p_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (fetch_t && pend_q) |-> (imem_req_addr == exp_q));
    end

    // R7: every valid stage is k threads behind the live fetch slot
    for (genvar k = 1; k < NSTAGE; k++) begin : g_align
        p_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (imem_req_valid && stage_vld[k]) |->
                (stage_tid[k*TID_W +: TID_W] == TID_W'(imem_req_tid - TID_W'(k))));
    end

    // R8: operand reads go to the decode-stage thread
    p_rd_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stage_vld[1] |-> (rf_rd_bank == stage_tid[TID_W +: TID_W]));

    // R9: at most one bank written, only for a valid writeback of that thread
    p_we_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rf_bank_we));

    p_we_qual_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_bank_we != '0) |->
            (wb_we_req && stage_vld[NSTAGE-1] && rf_bank_we[rf_wr_bank]));

    // R10: no thread occupies two of the stages after fetch
    for (genvar i = 1; i < NSTAGE; i++) begin : g_si
        for (genvar j = i + 1; j < NSTAGE; j++) begin : g_sj
            p_sep_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (stage_vld[i] && stage_vld[j]) |->
                    (stage_tid[i*TID_W +: TID_W] != stage_tid[j*TID_W +: TID_W]));
        end
    end

endmodule

bind barrel_ctrl barrel_ctrl_chk #(
    .NT         (NT),
    .NSTAGE     (NSTAGE),
    .ADDR_W     (ADDR_W),
    .INSN_BYTES (INSN_BYTES)
) u_barrel_chk (.*);

// File: tb/test_barrel_ctrl.sv
module test_barrel_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int RUN_CYCLES = 80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_req_valid;
    logic [31:0] imem_req_addr;
    logic [1:0]  imem_req_tid;
    logic [4:0]  stage_vld;
    logic [9:0]  stage_tid;
    logic [3:0]  redir_valid = '0;
    logic [127:0] redir_target = '0;
    logic        wb_we_req = 1'b0;
    logic [1:0]  rf_rd_bank;
    logic [1:0]  rf_wr_bank;
    logic [3:0]  rf_bank_we;

    int n_checks = 0;
    int n_fail = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    typedef struct packed {
        logic [1:0]  tid;
        logic [31:0] addr;
        logic [3:0]  code;
        logic [4:0]  svld;
        logic [9:0]  stid;
        logic        rdv;
        logic [1:0]  rdb;
        logic        wrv;
        logic [1:0]  wrb;
        logic [3:0]  bwe;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    barrel_ctrl i_barrel_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .imem_req_valid (imem_req_valid),
        .imem_req_addr  (imem_req_addr),
        .imem_req_tid   (imem_req_tid),
        .stage_vld      (stage_vld),
        .stage_tid      (stage_tid),
        .redir_valid    (redir_valid),
        .redir_target   (redir_target),
        .wb_we_req      (wb_we_req),
        .rf_rd_bank     (rf_rd_bank),
        .rf_wr_bank     (rf_wr_bank),
        .rf_bank_we     (rf_bank_we)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic string rname(input logic [3:0] code);
        case (code)
            4'd1:    return "R1";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            default: return "R3";
        endcase
    endfunction

    // Monitor: pops one expected item per issuing cycle
    always @(negedge clk) begin
        if (mon_en) begin
            if (!imem_req_valid) begin
                chk(1'b0, "R2", "fetch valid dropped", 32'(imem_req_valid), 32'd1);
            end else if (exp_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected fetch", 32'd1, 32'd0);
            end else begin
                exp_t e;
                bit   sep_ok;
                e = exp_q.pop_front();
                chk(imem_req_tid == e.tid, "R2", "fetch thread", 32'(imem_req_tid), 32'(e.tid));
                chk(imem_req_addr == e.addr, rname(e.code), "fetch address", imem_req_addr, e.addr);
                chk(stage_vld == e.svld, "R7", "stage valids", 32'(stage_vld), 32'(e.svld));
                chk(stage_tid == e.stid, "R7", "stage tags", 32'(stage_tid), 32'(e.stid));
                if (e.rdv) begin
                    chk(rf_rd_bank == e.rdb, "R8", "read bank", 32'(rf_rd_bank), 32'(e.rdb));
                end
                if (e.wrv) begin
                    chk(rf_wr_bank == e.wrb, "R9", "write bank", 32'(rf_wr_bank), 32'(e.wrb));
                end
                chk(rf_bank_we == e.bwe, "R9", "bank write enables", 32'(rf_bank_we), 32'(e.bwe));
                sep_ok = 1'b1;
                for (int i = 1; i < 5; i++) begin
                    for (int j = i + 1; j < 5; j++) begin
                        if (stage_vld[i] && stage_vld[j] &&
                            stage_tid[i*2 +: 2] == stage_tid[j*2 +: 2]) begin
                            sep_ok = 1'b0;
                        end
                    end
                end
                chk(sep_ok, "R10", "thread repeated in D..W", 32'(stage_tid), 32'(e.stid));
            end
        end
    end

    // Driver with its own per-thread program counter model
    initial begin
        logic [31:0] pc_m [4];
        logic [3:0]  pend_m [4];

        for (int t = 0; t < 4; t++) begin
            pc_m[t]   = 32'(t) * 32'h1000;
            pend_m[t] = 4'd1;
        end

        // Reset: outputs idle even with a write request pending (R1)
        wb_we_req = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(imem_req_valid == 1'b0, "R1", "valid in reset", 32'(imem_req_valid), 32'd0);
        chk(stage_vld == '0, "R1", "stage valids in reset", 32'(stage_vld), 32'd0);
        chk(rf_bank_we == '0, "R1", "bank we in reset", 32'(rf_bank_we), 32'd0);

        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(imem_req_valid == 1'b0, "R1", "valid first cycle", 32'(imem_req_valid), 32'd0);
        chk(stage_vld == '0, "R1", "stage valids first cycle", 32'(stage_vld), 32'd0);
        chk(rf_bank_we == '0, "R1", "bank we first cycle", 32'(rf_bank_we), 32'd0);

        for (int n = 0; n < RUN_CYCLES; n++) begin
            logic [3:0]  rv;
            logic [31:0] tg [4];
            logic        wbr;
            int          slot;
            exp_t        e;

            @(posedge clk);
            #1;
            rv = '0;
            for (int t = 0; t < 4; t++) tg[t] = '0;
            slot = n % 4;

            case (n)
                14: begin rv[0] = 1'b1; tg[0] = 32'h0000_8000; end           // R4: thread 0 in execute
                21: begin rv[1] = 1'b1; tg[1] = 32'h0000_9000; end           // R5: thread 1 fetching
                30: begin                                                  // R6: three threads at once
                        rv[0] = 1'b1; tg[0] = 32'h0000_A000;
                        rv[2] = 1'b1; tg[2] = 32'h0000_B000;
                        rv[3] = 1'b1; tg[3] = 32'h0000_C000;
                    end
                45: begin rv[2] = 1'b1; tg[2] = 32'h0000_D000; end           // R4 then
                46: begin rv[2] = 1'b1; tg[2] = 32'h0000_E000; end           // R5 on same thread
                60: begin                                                  // R6: all four threads
                        for (int t = 0; t < 4; t++) begin
                            rv[t] = 1'b1;
                            tg[t] = 32'h0001_0000 + 32'(t) * 32'h100;
                        end
                    end
                default: ;
            endcase

            wbr = !(n >= 40 && n < 48) && (n % 3 != 0);
            redir_valid  = rv;
            redir_target = {tg[3], tg[2], tg[1], tg[0]};
            wb_we_req    = wbr;

            e = '0;
            e.tid  = 2'(slot);
            e.addr = pc_m[slot];
            e.code = rv[slot] ? 4'd5 : pend_m[slot];
            for (int k = 0; k < 5; k++) begin
                if (n >= k) begin
                    e.svld[k]        = 1'b1;
                    e.stid[k*2 +: 2] = 2'((n - k) % 4);
                end
            end
            e.rdv = (n >= 1);
            e.rdb = (n >= 1) ? 2'((n - 1) % 4) : 2'd0;
            e.wrv = (n >= 4);
            e.wrb = (n >= 4) ? 2'((n - 4) % 4) : 2'd0;
            e.bwe = (wbr && n >= 4) ? (4'd1 << ((n - 4) % 4)) : 4'd0;
            exp_q.push_back(e);
            mon_en = 1'b1;

            for (int t = 0; t < 4; t++) begin
                if (rv[t]) begin
                    pc_m[t]   = tg[t];
                    pend_m[t] = ($countones(rv) > 1) ? 4'd6 : ((t == slot) ? 4'd5 : 4'd4);
                end else if (t == slot) begin
                    pc_m[t]   = pc_m[t] + 32'd4;
                    pend_m[t] = 4'd3;
                end
            end
        end

        @(posedge clk);
        #1;
        mon_en = 1'b0;
        redir_valid = '0;
        chk(exp_q.size() == 0, "R2", "items left unchecked", 32'(exp_q.size()), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule